// File: doc/BRIEF.md
# Serial Register-File Slave for a Clock-Generator Controller

This block is the two-wire serial slave through which a host configures a clock-generator controller. It holds a bank of 8-bit control registers. The rest of the chip sees all of them at once through a flat vector. The host reaches them with four protocols: single-byte write, single-byte read, block write and block read. The slave decodes the device address, the command byte, an optional byte count and the data bytes. It acknowledges by pulling the data line low and sends read data the same way. It never drives the line high.

The command byte chooses between two kinds of access. When its top bit is set, bits 6:0 give the index of one register, which is then written or read. A command of 0x00 selects block mode, and a block transfer always starts at register 0. Some bits in the map are not storage. They show live inputs from the chip: hardware-latched frequency straps, ratio readback, a mode strap and the watchdog-expired status. Two identification registers are constant. The register view handed to the chip already has the live inputs merged in. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `smbreg_slave`

## Requirements
- R1: The slave acknowledges only address byte 0xD2 (7-bit 0x69, write) and 0xD3 (read). Any other address is not acknowledged, and the bus is ignored until the next START.
- R2: After reset, every register holds its default. Examples: register 0 = 0xC4, register 2 = 0xFF, register 8 = 0x08, register 12 = 0x08, register 19 = 0x81.
- R3: Byte write is START, 0xD2, command {1, idx[6:0]}, one data byte, STOP. The data byte is acknowledged and stored in register idx. A second data byte in the same transfer is not acknowledged.
- R4: Byte read is START, 0xD2, command {1, idx}, repeated START, 0xD3, after which the slave returns register idx.
- R5: Block write is START, 0xD2, command 0x00, count N, then data bytes. The data bytes fill registers 0, 1, 2 and so on. A data byte is not acknowledged once N bytes have been taken or the last register (20) has been filled.
- R6: Block read is START, 0xD2, command 0x00, repeated START, 0xD3. The slave returns the count byte 21 (0x15), then registers 0 to 20 in order, for as long as the host acknowledges.
- R7: Registers 19 (0x81) and 20 (0x7C) are read-only. Writes to them are acknowledged but leave them unchanged.
- R8: Some bits read back live inputs, and host writes to those bits have no effect. Register 1 bits 3:0 show the frequency straps. Register 3 bits 1:0 show the ratio. Register 5 bit 7 shows the mode strap and bit 5 shows the watchdog-expired status.
- R9: A command byte with bit 7 clear that is not 0x00 is not acknowledged, and the slave goes idle.
- R10: A STOP at any point releases the data line and ends the transfer. A START at any point abandons the current transfer and begins a new address phase.
- R11: The slave only pulls the data line low or releases it, and changes its drive only while SCL (after synchronisation) is low.
- R12: Index values of 21 and above are out of range. A byte write to such an index is not acknowledged at the data byte and changes nothing, and a byte read from it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the pad (asynchronous) |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release |
| fs_strap_i | input | 4 | Latched frequency straps, read in register 1 bits 3:0 |
| ratio_i | input | 2 | Ratio readback, read in register 3 bits 1:0 |
| multsel_i | input | 1 | Mode strap, read in register 5 bit 7 |
| wd_expired_i | input | 1 | Watchdog-expired status, read in register 5 bit 5 |
| regs_o | output | 168 | All 21 registers with live bits merged; register k occupies bits 8k+7:8k |

## Verification
Two functions can act in the same cycle: a host write landing in register 5, and a change on the watchdog-expired input that feeds a bit of that same register. The bench raises the status input while a byte write to register 5 is still on the bus. It then reads the register back and expects the written bits in the storage positions and the live input in bit 5. A second read after the input drops shows that the stored write never captured the status bit.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RX_ACK,
    S_TX,
    S_TX_ACK
  } bus_st_e;

  typedef enum logic [1:0] {
    P_ADDR,
    P_CMD,
    P_CNT,
    P_DATA
  } rx_ph_e;

  // Power-up value of each register
  function automatic logic [7:0] reg_default(input int i);
    case (i)
      0:  return 8'hC4;
      1:  return 8'hE3;
      2:  return 8'hFF;
      3:  return 8'hF8;
      4:  return 8'h7F;
      5:  return 8'h80;
      8:  return 8'h08;
      9:  return 8'hAD;
      10: return 8'h67;
      11: return 8'h1F;
      12: return 8'h08;
      13: return 8'hA7;
      14: return 8'h90;
      15: return 8'h04;
      16: return 8'hFF;
      17: return 8'hFC;
      18: return 8'hFF;
      19: return 8'h81;
      20: return 8'h7C;
      default: return 8'h00;
    endcase
  endfunction

  // Bits the host may change (1 = writable)
  function automatic logic [7:0] reg_wmask(input int i);
    case (i)
      1:  return 8'hF0;
      3:  return 8'hFC;
      5:  return 8'h5F;
      19: return 8'h00;
      20: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/smbreg_sync_edge.sv
module smbreg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smbreg_bank.sv
module smbreg_bank
  import smbreg_pkg::*;
#(
  parameter int NREG  = 21,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  input  logic [3:0]       fs_strap,
  input  logic [1:0]       ratio,
  input  logic             multsel,
  input  logic             wd_expired,
  output logic [NREG*8-1:0] regs_o
);
  logic [7:0] view_a [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] WM  = reg_wmask(g);
    localparam logic [7:0] DEF = reg_default(g);
    logic [7:0] stored;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   stored <= DEF;
      else if (wr_en && wr_idx == IDX_W'(g))        stored <= (wr_data & WM) | (stored & ~WM);
    end

    if (g == 1) begin : g_fs
      assign view_a[g] = {stored[7:4], fs_strap};
    end else if (g == 3) begin : g_ratio
      assign view_a[g] = {stored[7:2], ratio};
    end else if (g == 5) begin : g_wd
      assign view_a[g] = {multsel, stored[6], wd_expired, stored[4:0]};
    end else begin : g_plain
      assign view_a[g] = stored;
    end

    assign regs_o[g*8 +: 8] = view_a[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IDX_W'(i)) rd_data = view_a[i];
  end
endmodule

// File: rtl/smbreg_ctrl.sv
module smbreg_ctrl
  import smbreg_pkg::*;
#(
  parameter int          NREG     = 21,
  parameter int          IDX_W    = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);
  localparam logic [IDX_W-1:0] NREG_I = IDX_W'(NREG);
  localparam logic [7:0]       NREG_B = 8'(NREG);

  bus_st_e          st;
  rx_ph_e           ph;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, txsh, remain;
  logic [IDX_W-1:0] idx;
  logic             blk, cnt_pend, to_tx, host_ack;
  logic             tx_avail;
  logic [7:0]       tx_next;

  assign rd_idx = idx;

  always_comb begin
    tx_avail = cnt_pend || (remain != 8'd0);
    tx_next  = cnt_pend ? NREG_B : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_ADDR; bitcnt <= '0; shreg <= '0; txsh <= '0;
      remain <= '0; idx <= '0; blk <= 1'b0; cnt_pend <= 1'b0; to_tx <= 1'b0;
      host_ack <= 1'b0; wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0; sda_pull <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        st <= S_IDLE; sda_pull <= 1'b0;
      end else if (start_det) begin
        st <= S_RX; ph <= P_ADDR; bitcnt <= '0; sda_pull <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0; st <= S_RX_ACK; sda_pull <= 1'b1; to_tx <= 1'b0;
              case (ph)
                P_ADDR: begin
                  if (shreg[7:1] != DEV_ADDR) begin
                    st <= S_IDLE; sda_pull <= 1'b0;
                  end else if (shreg[0]) begin
                    to_tx <= 1'b1;
                    if (blk) begin cnt_pend <= 1'b1; idx <= '0; end
                    else remain <= 8'd1;
                  end else ph <= P_CMD;
                end
                P_CMD: begin
                  if (shreg[7]) begin
                    blk <= 1'b0; idx <= shreg[IDX_W-1:0]; remain <= 8'd1; ph <= P_DATA;
                  end else if (shreg == 8'h00) begin
                    blk <= 1'b1; idx <= '0; ph <= P_CNT;
                  end else begin
                    st <= S_IDLE; sda_pull <= 1'b0;
                  end
                end
                P_CNT: begin
                  remain <= shreg; ph <= P_DATA;
                end
                default: begin
                  if (remain != 8'd0 && idx < NREG_I) begin
                    wr_en <= 1'b1; wr_idx <= idx; wr_data <= shreg;
                    idx <= idx + 1'b1; remain <= remain - 8'd1;
                  end else begin
                    st <= S_IDLE; sda_pull <= 1'b0;
                  end
                end
              endcase
            end
          end
          S_RX_ACK, S_TX_ACK: begin
            if (st == S_TX_ACK && scl_rise) host_ack <= ~sda_s;
            if (scl_fall) begin
              sda_pull <= 1'b0;
              if ((st == S_RX_ACK) && !to_tx) begin
                st <= S_RX;
              end else if (((st == S_RX_ACK) || host_ack) && tx_avail) begin
                txsh <= tx_next; sda_pull <= ~tx_next[7]; bitcnt <= '0; st <= S_TX;
                if (cnt_pend) begin
                  cnt_pend <= 1'b0; remain <= NREG_B; idx <= '0;
                end else begin
                  idx <= idx + 1'b1; remain <= remain - 8'd1;
                end
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_pull <= 1'b0; st <= S_TX_ACK;
              end else begin
                txsh     <= {txsh[6:0], 1'b0};
                sda_pull <= ~txsh[6];
                bitcnt   <= bitcnt + 4'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbreg_slave.sv
module smbreg_slave
  import smbreg_pkg::*;
#(
  parameter int         NREG     = 21,
  parameter int         SYNC_LEN = 2,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic [3:0]       fs_strap_i,
  input  logic [1:0]       ratio_i,
  input  logic             multsel_i,
  input  logic             wd_expired_i,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IDX_W = 7;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;

  smbreg_sync_edge #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbreg_ctrl #(.NREG(NREG), .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_pull(sda_pull_o)
  );

  smbreg_bank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .fs_strap(fs_strap_i), .ratio(ratio_i),
    .multsel(multsel_i), .wd_expired(wd_expired_i), .regs_o(regs_o)
  );
endmodule

// File: rtl/smbreg_checker.sv
module smbreg_checker #(
  parameter int NREG = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_pull,
  input logic              scl_s,
  input logic              stop_det,
  input logic              wr_en,
  input logic [6:0]        wr_idx,
  input logic [NREG*8-1:0] regs
);
  AST_PULL_ON_SCL_LOW:    assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_pull) |-> !scl_s); // R11
  AST_RELEASE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(sda_pull) |-> !scl_s); // R11
  AST_STOP_RELEASES:      assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !sda_pull); // R10
  AST_WRITE_ACKED:        assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> sda_pull); // R3
  AST_WRITE_IN_RANGE:     assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (int'(wr_idx) < NREG)); // R12
  if (NREG > 20) begin : g_id
    AST_ID_BYTES_FIXED:   assert property (@(posedge clk) disable iff (!rst_n)
                            (regs[19*8 +: 8] == 8'h81) && (regs[20*8 +: 8] == 8'h7C)); // R7
  end
endmodule

bind smbreg_slave smbreg_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull_o), .scl_s(scl_s), .stop_det(stop_det),
  .wr_en(wr_en), .wr_idx(wr_idx), .regs(regs_o)
);

// File: tb/smbreg_slave_bench.sv
module smbreg_slave_bench;
  localparam int NREG = 21;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic [3:0] fs_strap = 4'hA;
  logic [1:0] ratio = 2'b01;
  logic multsel = 1'b1, wd_exp = 1'b0;
  logic [NREG*8-1:0] regs;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_h & ~sda_pull;

  smbreg_slave u_smbreg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .fs_strap_i(fs_strap), .ratio_i(ratio), .multsel_i(multsel), .wd_expired_i(wd_exp),
    .regs_o(regs)
  );

  // {index, write data, expected readback}
  localparam logic [23:0] VEC [11] = '{
    24'h00_5A_5A, 24'h02_00_00, 24'h01_F0_FA, 24'h03_03_01, 24'h05_00_80, 24'h05_FF_DF,
    24'h13_00_81, 24'h14_FF_7C, 24'h08_33_33, 24'h12_12_12, 24'h0C_A5_A5 };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask
  task automatic bstart(); sda_h = 1'b1; w(Q); scl_h = 1'b1; w(Q); sda_h = 1'b0; w(Q); scl_h = 1'b0; w(Q); endtask
  task automatic bstop();  sda_h = 1'b0; w(Q); scl_h = 1'b1; w(Q); sda_h = 1'b1; w(Q); endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; w(Q); scl_h = 1'b1; w(2*Q); scl_h = 1'b0; w(Q);
    end
    sda_h = 1'b1; w(Q); scl_h = 1'b1; w(Q); ack = ~sda_line; w(Q); scl_h = 1'b0; w(Q);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(Q); scl_h = 1'b1; w(Q); b = {b[6:0], sda_line}; w(Q); scl_h = 1'b0; w(Q);
    end
    sda_h = ~give_ack; w(Q); scl_h = 1'b1; w(2*Q); scl_h = 1'b0; w(Q); sda_h = 1'b1;
  endtask

  task automatic byte_write(input logic [6:0] idx, input logic [7:0] d, output logic dack);
    logic a0, a1;
    bstart(); wbyte(8'hD2, a0); wbyte({1'b1, idx}, a1); wbyte(d, dack); bstop();
    dack = dack & a0 & a1;
  endtask

  task automatic byte_read(input logic [6:0] idx, output logic [7:0] d);
    logic a;
    bstart(); wbyte(8'hD2, a); wbyte({1'b1, idx}, a); bstart(); wbyte(8'hD3, a);
    rbyte(1'b0, d); bstop();
  endtask

  function automatic logic [7:0] exp_merge(input int i, input logic [7:0] v);
    case (i)
      1:  return (v & 8'hF0) | {4'h0, fs_strap};
      3:  return (v & 8'hFC) | {6'h0, ratio};
      5:  return (v & 8'h5F) | {multsel, 1'b0, wd_exp, 5'h0};
      19: return 8'h81;
      20: return 8'h7C;
      default: return v;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic ak, a1, a2;
    logic [7:0] d;
    w(4); rst_n = 1'b1; w(4);
    // R2 reset defaults
    chk("R2 reg0", regs[0*8 +: 8], 8'hC4);
    chk("R2 reg2", regs[2*8 +: 8], 8'hFF);
    chk("R2 reg8", regs[8*8 +: 8], 8'h08);
    chk("R2 reg12", regs[12*8 +: 8], 8'h08);
    chk("R2 reg19", regs[19*8 +: 8], 8'h81);
    chk("R8 reg1 strap merged", regs[1*8 +: 8], 8'hEA);
    chk("R11 idle released", {7'h0, sda_pull}, 8'h00);

    // R3 R4 R7 R8 table of writes and readbacks
    for (int k = 0; k < 11; k++) begin
      byte_write(VEC[k][22:16], VEC[k][15:8], ak);
      chk("R3 data ack", {7'h0, ak}, 8'h01);
      byte_read(VEC[k][22:16], d);
      chk("R4 R7 R8 readback", d, VEC[k][7:0]);
    end

    // R1 foreign address not acknowledged
    bstart(); wbyte(8'hD4, ak); wbyte(8'h80, a1); wbyte(8'h11, a2); bstop();
    chk("R1 foreign addr nack", {7'h0, ak}, 8'h00);
    byte_read(7'd0, d);
    chk("R1 foreign write ignored", d, 8'h5A);

    // R3 second data byte refused
    bstart(); wbyte(8'hD2, ak); wbyte(8'h88, ak); wbyte(8'h44, a1); wbyte(8'h55, a2); bstop();
    chk("R3 first byte ack", {7'h0, a1}, 8'h01);
    chk("R3 second byte nack", {7'h0, a2}, 8'h00);
    byte_read(7'd9, d);
    chk("R3 neighbour untouched", d, 8'hAD);

    // R9 bad command
    bstart(); wbyte(8'hD2, ak); wbyte(8'h05, a1); bstop();
    chk("R9 bad command nack", {7'h0, a1}, 8'h00);

    // R12 out of range
    byte_write(7'd25, 8'h66, ak);
    chk("R12 oor write nack", {7'h0, ak}, 8'h00);
    byte_read(7'd25, d);
    chk("R12 oor read zero", d, 8'h00);

    // R5 block write stops at count
    bstart(); wbyte(8'hD2, ak); wbyte(8'h00, ak); wbyte(8'h03, ak);
    wbyte(8'h11, a1); wbyte(8'h22, ak); wbyte(8'h33, ak); wbyte(8'h44, a2); bstop();
    chk("R5 block first ack", {7'h0, a1}, 8'h01);
    chk("R5 past count nack", {7'h0, a2}, 8'h00);
    byte_read(7'd1, d); chk("R5 reg1", d, exp_merge(1, 8'h22));
    byte_read(7'd3, d); chk("R5 reg3 untouched", d, 8'h01);

    // R5 block write stops at last register
    bstart(); wbyte(8'hD2, ak); wbyte(8'h00, ak); wbyte(8'd30, ak);
    a1 = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      wbyte(8'hC0 + 8'(i), ak); a1 = a1 & ak;
    end
    wbyte(8'hEE, a2); bstop();
    chk("R5 all regs acked", {7'h0, a1}, 8'h01);
    chk("R5 past last reg nack", {7'h0, a2}, 8'h00);

    // R6 block read
    bstart(); wbyte(8'hD2, ak); wbyte(8'h00, ak); bstart(); wbyte(8'hD3, ak);
    rbyte(1'b1, d);
    chk("R6 count byte", d, 8'h15);
    for (int i = 0; i < NREG; i++) begin
      rbyte(i != NREG - 1, d);
      chk("R6 block data", d, exp_merge(i, 8'hC0 + 8'(i)));
    end
    bstop();

    // R8 live inputs; write to reg5 overlaps status change
    fs_strap = 4'h5;
    byte_read(7'd1, d); chk("R8 strap live", d, 8'hC5);
    fork
      byte_write(7'd5, 8'hFF, ak);
      begin w(150); wd_exp = 1'b1; end
    join
    byte_read(7'd5, d); chk("R8 status with write", d, 8'hFF);
    wd_exp = 1'b0;
    byte_read(7'd5, d); chk("R8 status not stored", d, 8'hDF);

    // R10 STOP aborts block write
    bstart(); wbyte(8'hD2, ak); wbyte(8'h00, ak); wbyte(8'h05, ak);
    wbyte(8'h77, ak); wbyte(8'h66, ak); bstop();
    byte_read(7'd2, d); chk("R10 stop abort reg2", d, 8'hC2);
    byte_read(7'd0, d); chk("R10 stop abort reg0", d, 8'h77);

    // R10 START mid-transfer restarts
    bstart(); wbyte(8'hD2, ak); wbyte(8'h89, ak);
    bstart(); wbyte(8'hD2, ak); wbyte(8'h8A, ak); wbyte(8'h5E, ak); bstop();
    byte_read(7'd9, d);  chk("R10 restart reg9", d, 8'hC9);
    byte_read(7'd10, d); chk("R10 restart reg10", d, 8'h5E);

    // R2 reset again
    rst_n = 1'b0; w(3); rst_n = 1'b1; w(3);
    chk("R2 reg0 after reset", regs[0*8 +: 8], 8'hC4);
    chk("R2 reg10 after reset", regs[10*8 +: 8], 8'h67);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule